// File: doc/BRIEF.md
# Bank Select and Memory Mode Control

This block keeps two small control registers for a banked memory system and turns CPU addresses into physical bank addresses. A 2 KB window of CPU address space, from 0x1800 to 0x1FFF, shows one of sixteen banks at a time. Which bank is shown is decided by a 4-bit bank register. A second 4-bit register holds the memory-mode control bits. The block passes these bits to the memory logic and does not decode them.

Both registers are loaded by I/O output commands. The write data is taken from the low bits of the CPU address bus, because during the I/O cycle that bus carries the accumulator value. The data bus is not used. While the reset/interrupt-in-progress input is high, a multiplexer feeds the mode register from four configuration switches on every clock edge. When that input falls, the mode register keeps the last switch value.

Top module: `bank_mode_ctl`

## Requirements
- R1: While `rst_n` is low, the bank register reads 0 and `mem_mode` reads 0, with no clock edge needed.
- R2: A clock edge with `io_wr` high and `io_cmd` equal to 0x51 loads the bank register from `cpu_addr[3:0]`.
- R3: A clock edge with `io_wr` high, `io_cmd` equal to 0x59 and `hold_sw` low loads `mem_mode` from `cpu_addr[3:0]`.
- R4: On every clock edge while `hold_sw` is high, `mem_mode` loads `cfg_sw`. A 0x59 command in that cycle has no effect.
- R5: After `hold_sw` falls, `mem_mode` keeps its value until the next 0x59 command.
- R6: An edge with `io_wr` low, or with any command code other than 0x51 or 0x59, leaves both registers unchanged.
- R7: `win_hit` is high exactly when `cpu_addr` lies in 0x1800 to 0x1FFF inclusive.
- R8: On a window hit, `phys_addr` equals {bank[3:0], cpu_addr[10:0]}. Otherwise `phys_addr` is 0.
- R9: A 0x51 command also loads the bank register while `hold_sw` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_sw | input | 1 | Reset/interrupt in progress: select switches for the mode register |
| cfg_sw | input | 4 | Configuration switch value for the mode register |
| io_wr | input | 1 | I/O output command strobe, one cycle |
| io_cmd | input | 8 | I/O command code |
| cpu_addr | input | 14 | CPU address bus; low bits carry the write data during I/O |
| win_hit | output | 1 | Address falls inside the bank window |
| phys_addr | output | 15 | Physical banked address |
| mem_mode | output | 4 | Memory-mode control bits |

## Verification
The hardest case is a mode command that arrives in the same cycle as the switch override, followed by the first cycles after the override is released. The stimulus issues 0x59 while `hold_sw` is high with a switch value that differs from the bus value. It then drops `hold_sw` and idles for several cycles to show that the last switch value is kept. The bank register has no port of its own, so it is observed through `phys_addr` with an address inside the window after every write, including a write made during the override.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_BANK = 2'd1,
        CMD_MODE = 2'd2
    } bmc_cmd_e;
endpackage

// File: rtl/bmc_decode.sv
module bmc_decode
    import bmc_pkg::*;
#(
    parameter int          CMD_W     = 8,
    parameter logic [7:0]  BANK_CODE = 8'h51,
    parameter logic [7:0]  MODE_CODE = 8'h59
) (
    input  logic             io_wr,
    input  logic [CMD_W-1:0] io_cmd,
    output bmc_cmd_e         kind
);
    always_comb begin
        kind = CMD_NONE;
        if (io_wr) begin
            if (io_cmd == CMD_W'(BANK_CODE))      kind = CMD_BANK;
            else if (io_cmd == CMD_W'(MODE_CODE)) kind = CMD_MODE;
        end
    end
endmodule

// File: rtl/bmc_regs.sv
module bmc_regs
    import bmc_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_sw,
    input  bmc_cmd_e          kind,
    input  logic [BANK_W-1:0] bank_data,
    input  logic [MODE_W-1:0] mode_data,
    input  logic [MODE_W-1:0] cfg_sw,
    output logic [BANK_W-1:0] bank,
    output logic [MODE_W-1:0] mode
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [MODE_W-1:0] mode;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kind == CMD_BANK) st_d.bank = bank_data;
        // switch source wins over the bus source
        if (hold_sw)               st_d.mode = cfg_sw;
        else if (kind == CMD_MODE) st_d.mode = mode_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;
    assign mode = st_q.mode;
endmodule

// File: rtl/bmc_window.sv
module bmc_window #(
    parameter int                ADDR_W   = 14,
    parameter int                OFF_W    = 11,
    parameter int                BANK_W   = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 14'h1800
) (
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [BANK_W-1:0]       bank,
    output logic                    hit,
    output logic [BANK_W+OFF_W-1:0] phys
);
    localparam int                TAG_W   = ADDR_W - OFF_W;
    localparam logic [TAG_W-1:0]  WIN_TAG = WIN_BASE[ADDR_W-1:OFF_W];

    always_comb begin
        hit  = (cpu_addr[ADDR_W-1:OFF_W] == WIN_TAG);
        phys = hit ? {bank, cpu_addr[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/bank_mode_ctl.sv
module bank_mode_ctl
    import bmc_pkg::*;
#(
    parameter int                ADDR_W    = 14,
    parameter int                OFF_W     = 11,
    parameter int                BANK_W    = 4,
    parameter int                MODE_W    = 4,
    parameter int                CMD_W     = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 14'h1800,
    parameter logic [7:0]        BANK_CODE = 8'h51,
    parameter logic [7:0]        MODE_CODE = 8'h59
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold_sw,
    input  logic [MODE_W-1:0]       cfg_sw,
    input  logic                    io_wr,
    input  logic [CMD_W-1:0]        io_cmd,
    input  logic [ADDR_W-1:0]       cpu_addr,
    output logic                    win_hit,
    output logic [BANK_W+OFF_W-1:0] phys_addr,
    output logic [MODE_W-1:0]       mem_mode
);
    bmc_cmd_e          kind;
    logic [BANK_W-1:0] bank_q;

    bmc_decode #(.CMD_W(CMD_W), .BANK_CODE(BANK_CODE), .MODE_CODE(MODE_CODE)) u_dec (
        .io_wr (io_wr),
        .io_cmd(io_cmd),
        .kind  (kind)
    );

    bmc_regs #(.BANK_W(BANK_W), .MODE_W(MODE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_sw  (hold_sw),
        .kind     (kind),
        .bank_data(cpu_addr[BANK_W-1:0]),
        .mode_data(cpu_addr[MODE_W-1:0]),
        .cfg_sw   (cfg_sw),
        .bank     (bank_q),
        .mode     (mem_mode)
    );

    bmc_window #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .WIN_BASE(WIN_BASE)) u_win (
        .cpu_addr(cpu_addr),
        .bank    (bank_q),
        .hit     (win_hit),
        .phys    (phys_addr)
    );
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
    parameter int                ADDR_W    = 14,
    parameter int                OFF_W     = 11,
    parameter int                BANK_W    = 4,
    parameter int                MODE_W    = 4,
    parameter int                CMD_W     = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 14'h1800,
    parameter logic [7:0]        BANK_CODE = 8'h51,
    parameter logic [7:0]        MODE_CODE = 8'h59
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hold_sw,
    input logic [MODE_W-1:0]       cfg_sw,
    input logic                    io_wr,
    input logic [CMD_W-1:0]        io_cmd,
    input logic [ADDR_W-1:0]       cpu_addr,
    input logic [BANK_W-1:0]       bank,
    input logic                    win_hit,
    input logic [BANK_W+OFF_W-1:0] phys_addr,
    input logic [MODE_W-1:0]       mem_mode
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'((1 << OFF_W) - 1);

    logic is_bank_wr, is_mode_wr;
    assign is_bank_wr = io_wr && (io_cmd == CMD_W'(BANK_CODE));
    assign is_mode_wr = io_wr && (io_cmd == CMD_W'(MODE_CODE));

    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (bank == '0 && mem_mode == '0);
        end
    end

    p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_bank_wr |=> bank == $past(cpu_addr[BANK_W-1:0]));

    p_mode_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode_wr && !hold_sw) |=> mem_mode == $past(cpu_addr[MODE_W-1:0]));

    p_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_sw |=> mem_mode == $past(cfg_sw));

    p_mode_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_sw && !is_mode_wr) |=> $stable(mem_mode));

    p_bank_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_bank_wr |=> $stable(bank));

    p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit == ({1'b0, cpu_addr} >= WIN_LO && {1'b0, cpu_addr} <= WIN_HI));

    p_phys_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> phys_addr == {bank, cpu_addr[OFF_W-1:0]});

    p_phys_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> phys_addr == '0);
endmodule

bind bank_mode_ctl bmc_chk #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .MODE_W(MODE_W), .CMD_W(CMD_W),
    .WIN_BASE(WIN_BASE), .BANK_CODE(BANK_CODE), .MODE_CODE(MODE_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_sw(hold_sw), .cfg_sw(cfg_sw), .io_wr(io_wr),
    .io_cmd(io_cmd), .cpu_addr(cpu_addr), .bank(bank_q), .win_hit(win_hit),
    .phys_addr(phys_addr), .mem_mode(mem_mode)
);

// File: tb/bank_mode_ctl_tb.sv
module bank_mode_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_sw = 1'b1;
    logic [3:0]  cfg_sw = 4'hA;
    logic        io_wr = 1'b0;
    logic [7:0]  io_cmd = 8'h00;
    logic [13:0] cpu_addr = 14'h1800;
    logic        win_hit;
    logic [14:0] phys_addr;
    logic [3:0]  mem_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .hold_sw(hold_sw), .cfg_sw(cfg_sw),
        .io_wr(io_wr), .io_cmd(io_cmd), .cpu_addr(cpu_addr),
        .win_hit(win_hit), .phys_addr(phys_addr), .mem_mode(mem_mode)
    );

    typedef struct {
        logic [3:0]  mode;
        logic        hit;
        logic [14:0] phys;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic [3:0] m_bank = 4'h0;
    logic [3:0] m_mode = 4'h0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and predicts the outputs after the edge
    task automatic step(input logic wr, input logic [7:0] cmd, input logic [13:0] addr,
                        input logic hold, input logic [3:0] sw, input string req);
        exp_t e;
        @(negedge clk);
        io_wr = wr; io_cmd = cmd; cpu_addr = addr; hold_sw = hold; cfg_sw = sw;
        if (wr && cmd == 8'h51) m_bank = addr[3:0];
        if (hold) m_mode = sw;
        else if (wr && cmd == 8'h59) m_mode = addr[3:0];
        e.mode = m_mode;
        e.hit  = (addr >= 14'h1800) && (addr <= 14'h1FFF);
        e.phys = e.hit ? {m_bank, addr[10:0]} : 15'h0;
        e.req  = req;
        sbq.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(e.req, "mem_mode", int'(mem_mode), int'(e.mode));
                check(e.req, "win_hit", int'(win_hit), int'(e.hit));
                check(e.req, "phys_addr", int'(phys_addr), int'(e.phys));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, observed while the clock runs and hold is high
        repeat (3) @(negedge clk);
        check("R1", "mem_mode", int'(mem_mode), 0);
        check("R1", "phys_addr", int'(phys_addr), 0);
        cpu_addr = 14'h1FFF;
        #1;
        check("R1", "phys_addr", int'(phys_addr), 'h07FF);
        rst_n = 1'b1;

        step(1'b0, 8'h00, 14'h1800, 1'b1, 4'hA, "R4");
        step(1'b1, 8'h59, 14'h0003, 1'b1, 4'h5, "R4");   // bus value ignored
        step(1'b0, 8'h00, 14'h0000, 1'b0, 4'hC, "R5");
        step(1'b0, 8'h00, 14'h0400, 1'b0, 4'h9, "R5");
        step(1'b1, 8'h59, 14'h0006, 1'b0, 4'hC, "R3");
        step(1'b1, 8'h51, 14'h1809, 1'b0, 4'h0, "R2");
        step(1'b1, 8'h52, 14'h1803, 1'b0, 4'h0, "R6");
        step(1'b1, 8'h58, 14'h000F, 1'b0, 4'h0, "R6");
        step(1'b1, 8'h50, 14'h1801, 1'b0, 4'h0, "R6");
        step(1'b0, 8'h51, 14'h1804, 1'b0, 4'h0, "R6");
        step(1'b0, 8'h59, 14'h1807, 1'b0, 4'h0, "R6");
        step(1'b0, 8'h00, 14'h17FF, 1'b0, 4'h0, "R7");
        step(1'b0, 8'h00, 14'h1800, 1'b0, 4'h0, "R7");
        step(1'b0, 8'h00, 14'h1FFF, 1'b0, 4'h0, "R7");
        step(1'b0, 8'h00, 14'h2000, 1'b0, 4'h0, "R7");
        step(1'b0, 8'h00, 14'h3800, 1'b0, 4'h0, "R8");
        step(1'b0, 8'h00, 14'h0800, 1'b0, 4'h0, "R8");
        step(1'b1, 8'h51, 14'h000F, 1'b1, 4'h2, "R9");
        step(1'b0, 8'h00, 14'h1ABC, 1'b0, 4'h7, "R9");
        step(1'b0, 8'h00, 14'h1234, 1'b0, 4'h7, "R5");
        for (int b = 0; b < 16; b++) begin
            step(1'b1, 8'h51, 14'(b) | 14'h1840, 1'b0, 4'h0, "R2");
            step(1'b0, 8'h00, 14'h1F00 | 14'(b), 1'b0, 4'h0, "R8");
        end
        for (int m = 0; m < 16; m++) begin
            step(1'b1, 8'h59, 14'h2A0 | 14'(m), 1'b0, 4'h0, "R3");
        end
        step(1'b0, 8'h00, 14'h0000, 1'b1, 4'hE, "R4");
        step(1'b1, 8'h59, 14'h0001, 1'b1, 4'hB, "R4");
        step(1'b0, 8'h00, 14'h0000, 1'b0, 4'h3, "R5");

        @(negedge clk);
        io_wr = 1'b0;
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule